// File: doc/BRIEF.md
# Overcurrent Integrating Fault and Restart Controller

This block decides, one clock at a time, whether a phase-shifted bridge converter may deliver power. It watches a cycle-by-cycle current-limit flag and keeps a digital fault level. The level is charged in fixed steps when overcurrent is present and leaks away in proportion to its own size when it is not. A single current-limit event therefore leaves only a small bump that dies out. A sustained overload pushes the level up to a shutdown threshold. The block then inhibits the gate drivers until the level has leaked down to a lower resume threshold.

Every entry into operation passes through a soft start. This applies after a supply comes good, after a supply loss, and after a fault. During soft start a duty-limit word starts from zero and climbs by a fixed amount on each oscillator tick until it reaches full scale. The phase modulator clamps its phase command to this word, so output power rises gradually. A supply-good flag, produced upstream by an undervoltage detector with hysteresis, gates everything: losing it inhibits the drivers at once and clears all of the block's state.

Charge and leak rates are stated per oscillator tick, which arrives as a one-cycle `osc_tick` pulse.

Top module: `ocp_restart_ctl`

## Requirements
- R1: While `supply_ok` is low, `inhibit` is high in the same cycle. On the following clock `status` is 0, and `fault_level` and `ss_limit` are both 0.
- R2: After `supply_ok` is seen high in the off state, `status` becomes 1 (soft start) with `ss_limit` at 0. Each `osc_tick` then raises `ss_limit` by SS_STEP, saturating at all ones. When it reaches all ones, `status` becomes 2 (running).
- R3: An `ilim_trip` during soft start or running arms the charge source. On the next `osc_tick`, `fault_level` rises by CHARGE_STEP, saturating at all ones. That tick disarms the source unless `ilim_trip` is high in the same cycle.
- R4: On an `osc_tick` with the charge source disarmed, `fault_level` drops by `fault_level >> DECAY_SHIFT`. When that amount is 0, it drops by 1 instead, and it never goes below 0.
- R5: When `fault_level` is at or above SHUT_LVL in soft start or running, the next clock sets `status` to 3 (faulted), `inhibit` to 1 and `ss_limit` to 0, and disarms the charge source.
- R6: In the faulted state `ilim_trip` has no effect: `fault_level` never rises, and each `osc_tick` lowers it as in R4.
- R7: In the faulted state, once `fault_level` is at or below RESUME_LVL, the next clock sets `status` to 1 with `ss_limit` at 0.
- R8: The `status` codes are 0 off, 1 soft start, 2 running, 3 faulted. `inhibit` is low exactly when `supply_ok` is high and `status` is 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above undervoltage threshold |
| ilim_trip | input | 1 | Cycle-by-cycle current-limit comparator flag |
| osc_tick | input | 1 | One-cycle pulse at each oscillator cycle start |
| inhibit | output | 1 | Holds all gate drivers off |
| ss_limit | output | SS_W | Soft-start cap on the phase command |
| status | output | 2 | Operating state code |
| fault_level | output | LVL_W | Integrated fault level |

## Verification
The properties assume that `osc_tick` is a single-cycle pulse. They also assume that the synchronised inputs `ilim_trip` and `supply_ok` change only between clock edges. Under these assumptions each state change is visible one clock after its cause. The stimulus gives a tick every fourth cycle and drives every input on the falling edge. Trips are either isolated or held for long stretches. Supply drops are placed during running, during soft start and during a fault, so that each transition is reached from more than one state.

// File: rtl/ocp_restart_ctl.sv
module ocp_restart_ctl #(
  parameter int LVL_W       = 12,
  parameter int SHUT_LVL    = 2000,
  parameter int RESUME_LVL  = 1000,
  parameter int CHARGE_STEP = 300,
  parameter int DECAY_SHIFT = 4,
  parameter int SS_W        = 8,
  parameter int SS_STEP     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             ilim_trip,
  input  logic             osc_tick,
  output logic             inhibit,
  output logic [SS_W-1:0]  ss_limit,
  output logic [1:0]       status,
  output logic [LVL_W-1:0] fault_level
);
  localparam logic [LVL_W:0]   LVL_TOP = {1'b0, {LVL_W{1'b1}}};
  localparam logic [LVL_W:0]   CHG     = (LVL_W+1)'(CHARGE_STEP);
  localparam logic [LVL_W-1:0] SHUT_L  = LVL_W'(SHUT_LVL);
  localparam logic [LVL_W-1:0] RES_L   = LVL_W'(RESUME_LVL);
  localparam logic [SS_W:0]    SS_INC  = (SS_W+1)'(SS_STEP);
  localparam logic [SS_W-1:0]  SS_TOP  = '1;

  typedef enum logic [1:0] {ST_OFF = 2'd0, ST_SOFT = 2'd1, ST_RUN = 2'd2, ST_FAULT = 2'd3} st_t;

  st_t              st;
  logic [LVL_W-1:0] level;
  logic             charge_on;
  logic [SS_W-1:0]  ss;

  wire [LVL_W:0]   lvl_sum     = {1'b0, level} + CHG;
  wire [LVL_W-1:0] lvl_charged = (lvl_sum > LVL_TOP) ? '1 : lvl_sum[LVL_W-1:0];
  wire [LVL_W-1:0] leak        = level >> DECAY_SHIFT;
  wire [LVL_W-1:0] lvl_decayed = (leak != '0) ? level - leak :
                                 (level != '0) ? level - 1'b1 : level;
  wire [SS_W:0]    ss_sum      = {1'b0, ss} + SS_INC;
  wire [SS_W-1:0]  ss_next     = ss_sum[SS_W] ? SS_TOP : ss_sum[SS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_OFF; level <= '0; charge_on <= 1'b0; ss <= '0;
    end else if (!supply_ok) begin
      st <= ST_OFF; level <= '0; charge_on <= 1'b0; ss <= '0;
    end else begin
      case (st)
        ST_OFF: begin
          st <= ST_SOFT;
          ss <= '0;
        end
        ST_SOFT, ST_RUN: begin
          if (level >= SHUT_L) begin
            st        <= ST_FAULT;
            ss        <= '0;
            charge_on <= 1'b0;
          end else begin
            if (osc_tick) level <= charge_on ? lvl_charged : lvl_decayed;
            charge_on <= ilim_trip | (charge_on & ~osc_tick);
            if (st == ST_SOFT && osc_tick) begin
              ss <= ss_next;
              if (ss_next == SS_TOP) st <= ST_RUN;
            end
          end
        end
        default: begin
          charge_on <= 1'b0;
          if (level <= RES_L) begin
            st <= ST_SOFT;
            ss <= '0;
          end else if (osc_tick) begin
            level <= lvl_decayed;
          end
        end
      endcase
    end
  end

  assign inhibit     = !supply_ok || st == ST_OFF || st == ST_FAULT;
  assign ss_limit    = ss;
  assign status      = st;
  assign fault_level = level;
endmodule

module ocp_restart_chk #(
  parameter int LVL_W      = 12,
  parameter int SHUT_LVL   = 2000,
  parameter int RESUME_LVL = 1000,
  parameter int SS_W       = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_ok,
  input logic             inhibit,
  input logic [SS_W-1:0]  ss_limit,
  input logic [1:0]       status,
  input logic [LVL_W-1:0] fault_level
);
  localparam logic [LVL_W-1:0] SHUT_L = LVL_W'(SHUT_LVL);
  localparam logic [LVL_W-1:0] RES_L  = LVL_W'(RESUME_LVL);
  localparam logic [SS_W-1:0]  SS_TOP = '1;

  // R1
  supply_loss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (status == 2'd0 && fault_level == '0 && ss_limit == '0));
  // R2
  ss_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd1) |=> (ss_limit >= $past(ss_limit) || inhibit));
  // R2
  run_full_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2) |-> (ss_limit == SS_TOP));
  // R5
  shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && (status == 2'd1 || status == 2'd2) && fault_level >= SHUT_L)
      |=> (inhibit && ss_limit == '0));
  // R6
  fault_no_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd3) |=> (fault_level <= $past(fault_level)));
  // R7
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && status == 2'd3 && fault_level <= RES_L)
      |=> ((status == 2'd1 || status == 2'd0) && ss_limit == '0));
  // R8
  drive_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && (status == 2'd1 || status == 2'd2)) |-> !inhibit);
endmodule

bind ocp_restart_ctl ocp_restart_chk #(
  .LVL_W(LVL_W), .SHUT_LVL(SHUT_LVL), .RESUME_LVL(RESUME_LVL), .SS_W(SS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .inhibit(inhibit),
  .ss_limit(ss_limit), .status(status), .fault_level(fault_level)
);

// File: tb/sim_ocp_restart_ctl.sv
module sim_ocp_restart_ctl;
  localparam int CLK_P = 10;
  localparam int SHUT = 2000, RESUME = 1000, CSTEP = 300, DSH = 4, SSTEP = 32;
  localparam int LMAX = 4095, SMAX = 255;

  logic clk = 1'b0, rst_n = 1'b0, supply_ok = 1'b0, ilim_trip = 1'b0, osc_tick = 1'b0;
  logic inhibit;
  logic [7:0]  ss_limit;
  logic [1:0]  status;
  logic [11:0] fault_level;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_st = 0, m_lvl = 0, m_chg = 0, m_ss = 0;
  string lvl_tag, ss_tag, inh_tag;

  always #(CLK_P/2) clk = ~clk;

  ocp_restart_ctl u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ilim_trip(ilim_trip),
    .osc_tick(osc_tick), .inhibit(inhibit), .ss_limit(ss_limit),
    .status(status), .fault_level(fault_level)
  );

  task automatic check(input int act, input int exp, input string tag, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  function automatic int decay(input int v);
    int sh = v >> DSH;
    if (sh != 0) return v - sh;
    if (v != 0) return v - 1;
    return v;
  endfunction

  task automatic model_step();
    lvl_tag = "R4"; ss_tag = "R2"; inh_tag = "R8";
    if (!supply_ok) begin
      m_st = 0; m_lvl = 0; m_chg = 0; m_ss = 0;
      lvl_tag = "R1"; ss_tag = "R1"; inh_tag = "R1";
    end else if (m_st == 0) begin
      m_st = 1; m_ss = 0;
    end else if (m_st == 3) begin
      lvl_tag = "R6"; ss_tag = "R7"; inh_tag = "R6";
      m_chg = 0;
      if (m_lvl <= RESUME) begin m_st = 1; m_ss = 0; end
      else if (osc_tick) m_lvl = decay(m_lvl);
    end else if (m_lvl >= SHUT) begin
      m_st = 3; m_ss = 0; m_chg = 0;
      ss_tag = "R5"; inh_tag = "R5";
    end else begin
      if (osc_tick) begin
        if (m_chg != 0) begin
          lvl_tag = "R3";
          m_lvl = (m_lvl + CSTEP > LMAX) ? LMAX : m_lvl + CSTEP;
        end else m_lvl = decay(m_lvl);
      end
      m_chg = ilim_trip ? 1 : (osc_tick ? 0 : m_chg);
      if (m_st == 1 && osc_tick) begin
        m_ss = (m_ss + SSTEP > SMAX) ? SMAX : m_ss + SSTEP;
        if (m_ss == SMAX) m_st = 2;
      end
    end
  endtask

  task automatic compare_all();
    int exp_inh;
    exp_inh = (!supply_ok || m_st == 0 || m_st == 3) ? 1 : 0;
    check(int'(status), m_st, "R8", "status");
    check(int'(inhibit), exp_inh, inh_tag, "inhibit");
    check(int'(fault_level), m_lvl, lvl_tag, "fault_level");
    check(int'(ss_limit), m_ss, ss_tag, "ss_limit");
  endtask

  // mode: 0 no trip, 1 trip every cycle, 2 trip on first cycle only
  task automatic run(input int n, input bit sup, input int mode);
    for (int i = 0; i < n; i++) begin
      supply_ok = sup;
      ilim_trip = (mode == 1) || (mode == 2 && i == 0);
      osc_tick  = (cyc % 4 == 3);
      @(posedge clk);
      model_step();
      @(negedge clk);
      cyc++;
      compare_all();
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R1, R8)
    check(int'(status), 0, "R8", "reset status");
    check(int'(inhibit), 1, "R1", "reset inhibit");
    check(int'(fault_level), 0, "R1", "reset fault_level");
    check(int'(ss_limit), 0, "R1", "reset ss_limit");
    rst_n = 1'b1;
    run(5, 1'b0, 0);
    // soft start ramp to running (R2)
    run(50, 1'b1, 0);
    // isolated trips decay harmlessly (R3, R4)
    for (int k = 0; k < 3; k++) begin
      run(1, 1'b1, 2);
      run(40, 1'b1, 0);
    end
    // sustained overload: shutdown, ignored trips, resume (R5, R6, R7)
    run(80, 1'b1, 1);
    run(200, 1'b1, 0);
    // supply loss while running (R1)
    run(3, 1'b0, 0);
    run(20, 1'b1, 0);
    // supply loss during soft start (R1)
    run(2, 1'b0, 1);
    run(60, 1'b1, 0);
    // supply loss during a fault (R1, R6)
    run(40, 1'b1, 1);
    run(3, 1'b0, 1);
    run(80, 1'b1, 0);
    finish_up();
  end
endmodule